// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32.768 kHz timebase, delivered as a one-cycle step enable in the system clock domain, into periodic interrupt ticks. A 4-bit rate code sets the tick period. Codes 3 to 15 give a period of 2^(code-1) timebase steps. Codes 1 and 2 are first moved up by seven, so they behave like codes 8 and 9. Code 0 turns the ticks off.

Ticks run only while the periodic enable input is high and the rate code is non-zero. Each tick pulses a flag-set output. It also pulses an interrupt-request output when the periodic enable is set.

Ticks come from a 15-bit free-running count of timebase steps. A tick fires on the step that brings that count to a multiple of the period. All ticks therefore sit on period boundaries of one global count, and enabling the ticks does not restart the count. While the divider-reset input is held, the count is held at zero and no ticks are produced.

Top module: `periodic_irq_divider`

## Requirements
- R1: During and directly after synchronous reset, both `flag_set_o` and `irq_req_o` are low and the step count is zero.
- R2: With `rate_code_i` equal to 0, no tick is produced, whatever the other inputs are.
- R3: With `periodic_en_i` low, neither output pulses.
- R4: For rate codes 3 to 15, ticks are spaced 2^(code-1) timebase steps apart.
- R5: Rate code 1 gives the period of code 8 (128 steps), and rate code 2 gives the period of code 9 (256 steps).
- R6: A tick falls on the step that brings the free-running 15-bit count to a multiple of the period. Turning the enable on in the middle of a period does not restart the count.
- R7: A change of rate code or enable applies from the next timebase step.
- R8: While `div_hold_i` is high, the count is held at zero and no ticks occur. After it is released, counting resumes from zero.
- R9: Outputs are registered. A tick appears one clock after the qualifying `tb_step_i` cycle, as a one-cycle pulse on `flag_set_o`, and `irq_req_o` pulses in the same cycle.
- R10: The count advances only in cycles where `tb_step_i` is high, and it wraps from 32767 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_step_i | input | 1 | One-cycle pulse for each 32.768 kHz timebase step |
| rate_code_i | input | 4 | Period select code |
| periodic_en_i | input | 1 | Periodic interrupt enable |
| div_hold_i | input | 1 | Holds the step divider in reset |
| flag_set_o | output | 1 | Pulse that sets the periodic flag |
| irq_req_o | output | 1 | Pulse that requests the periodic interrupt |

## Verification
The hardest case to reach is a tick at the slowest rates and right at the 15-bit wrap, because 16384 steps must pass between ticks. The stimulus steps the timebase in every clock and runs each rate code for two full periods, so the count crosses its wrap point. Alignment is tested separately: the enable is switched on part-way through a period and the bench checks that the first tick lands on the global boundary. Random phases then mix timebase gaps, divider holds and rate changes in the middle of a period.

// File: rtl/rpi_pkg.sv
package rpi_pkg;

    localparam int RATE_W = 4;

    typedef struct packed {
        logic              active;
        logic [4:0]        shift;
    } rpi_sched_t;

    // Exponent of the period in timebase steps; low codes alias upward by seven.
    function automatic logic [4:0] rate_shift(input logic [RATE_W-1:0] code);
        logic [4:0] eff;
        eff = {1'b0, code};
        if (code == 4'd1 || code == 4'd2)
            eff = eff + 5'd7;
        return (eff == 5'd0) ? 5'd0 : eff - 5'd1;
    endfunction

endpackage

// File: rtl/rpi_timebase_cnt.sv
module rpi_timebase_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o
);
    logic [CNT_W-1:0] cnt_q;

    assign nxt_o = cnt_q + CNT_W'(1);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_i)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= nxt_o;
    end

    // R8: a held divider leaves the count at zero
    a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_q == '0));

    // R10: count only moves on a timebase step
    a_r10_no_step_stable: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !hold_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rpi_rate_decode.sv
module rpi_rate_decode
    import rpi_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [RATE_W-1:0] code_i,
    input  logic              pie_i,
    output logic [CNT_W-1:0]  mask_o,
    output logic              active_o
);
    rpi_sched_t sched;

    always_comb begin
        sched.active = pie_i && (code_i != '0);
        sched.shift  = rate_shift(code_i);
    end

    assign active_o = sched.active;

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = sched.active && (i < int'(sched.shift));
    end
endmodule

// File: rtl/rpi_tick_gen.sv
module rpi_tick_gen #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             hold_i,
    input  logic             active_i,
    input  logic             pie_i,
    input  logic [CNT_W-1:0] mask_i,
    input  logic [CNT_W-1:0] nxt_i,
    output logic             flag_o,
    output logic             irq_o
);
    logic tick;
    logic flag_q, irq_q;

    assign tick = step_i && !hold_i && active_i && ((nxt_i & mask_i) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= tick;
            irq_q  <= tick && pie_i;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    // R2, R3: no tick unless the schedule was active
    a_r3_tick_needs_active: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> $past(active_i));

    // R9: request only together with the flag
    a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> flag_q);

    // R9: single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> !flag_q);

    // R8: no tick out of a held divider
    a_r8_no_tick_held: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> !$past(hold_i));
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import rpi_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_step_i,
    input  logic [RATE_W-1:0] rate_code_i,
    input  logic              periodic_en_i,
    input  logic              div_hold_i,
    output logic              flag_set_o,
    output logic              irq_req_o
);
    logic [CNT_W-1:0] cnt, nxt, mask;
    logic             active;

    rpi_timebase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step_i (tb_step_i),
        .hold_i (div_hold_i),
        .cnt_o  (cnt),
        .nxt_o  (nxt)
    );

    rpi_rate_decode #(.CNT_W(CNT_W)) u_dec (
        .code_i   (rate_code_i),
        .pie_i    (periodic_en_i),
        .mask_o   (mask),
        .active_o (active)
    );

    rpi_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .step_i   (tb_step_i),
        .hold_i   (div_hold_i),
        .active_i (active),
        .pie_i    (periodic_en_i),
        .mask_i   (mask),
        .nxt_i    (nxt),
        .flag_o   (flag_set_o),
        .irq_o    (irq_req_o)
    );

    // R6: every tick lands on a period boundary of the global count
    a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
        flag_set_o |-> ((cnt & $past(mask)) == '0));
endmodule

// File: tb/periodic_irq_divider_tb.sv
module periodic_irq_divider_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       tb_step;
    logic [3:0] code;
    logic       pie;
    logic       hold;
    logic       flag, irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag;
    logic [14:0] mcnt;
    logic        exp_flag, exp_irq;

    always #10 clk = ~clk;

    periodic_irq_divider u_dut (
        .clk           (clk),
        .rst           (rst),
        .tb_step_i     (tb_step),
        .rate_code_i   (code),
        .periodic_en_i (pie),
        .div_hold_i    (hold),
        .flag_set_o    (flag),
        .irq_req_o     (irq)
    );

    function automatic logic [14:0] period_mask(input logic [3:0] c);
        int e;
        e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
        if (e == 0) return 15'd0;
        return 15'((32'd1 << (e - 1)) - 1);
    endfunction

    task automatic check_outputs();
        n_checks++;
        if (flag !== exp_flag) begin
            n_fail++;
            $display("FAIL %s flag_set got %0b expected %0b (mcnt %0d)", tag, flag, exp_flag, mcnt);
        end
        n_checks++;
        if (irq !== exp_irq) begin
            n_fail++;
            $display("FAIL R9/%s irq_req got %0b expected %0b", tag, irq, exp_irq);
        end
    endtask

    task automatic step(input logic s, input logic [3:0] c, input logic p, input logic h);
        logic [14:0] n;
        @(negedge clk);
        check_outputs();
        tb_step = s; code = c; pie = p; hold = h;
        n = mcnt + 15'd1;
        exp_flag = s && !h && p && (c != 4'd0) && ((n & period_mask(c)) == 15'd0);
        exp_irq  = exp_flag && p;
        if (h) mcnt = 15'd0;
        else if (s) mcnt = n;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1; tb_step = 1'b0; code = 4'd0; pie = 1'b0; hold = 1'b0;
        mcnt = '0; exp_flag = 1'b0; exp_irq = 1'b0;
        tag = "R1";
        repeat (3) begin
            @(negedge clk);
            check_outputs();
        end
        @(negedge clk);
        rst = 1'b0;
        // R1: nothing pulses right after reset, count begins at zero
        repeat (4) step(1'b0, 4'd3, 1'b1, 1'b0);

        // R4: every linear code for two full periods, stepping each clock
        tag = "R4";
        for (int c = 3; c <= 15; c++) begin
            repeat ((2 << (c - 1)) + 5) step(1'b1, 4'(c), 1'b1, 1'b0);
        end

        // R5: aliased low codes
        tag = "R5";
        repeat (2 * 128 + 7) step(1'b1, 4'd1, 1'b1, 1'b0);
        repeat (2 * 256 + 7) step(1'b1, 4'd2, 1'b1, 1'b0);

        // R2: code zero never ticks
        tag = "R2";
        repeat (300) step(1'b1, 4'd0, 1'b1, 1'($urandom));

        // R3: enable low never ticks
        tag = "R3";
        repeat (300) step(1'b1, 4'd3, 1'b0, 1'b0);

        // R6: enable mid-period, first tick on the global boundary
        tag = "R6";
        repeat (37) step(1'b1, 4'd5, 1'b0, 1'b0);
        repeat (60) step(1'b1, 4'd5, 1'b1, 1'b0);

        // R7: rate changes every few steps
        tag = "R7";
        for (int k = 0; k < 400; k++) begin
            logic [3:0] rc;
            rc = 4'(3 + ($urandom % 4));
            repeat (1 + ($urandom % 9)) step(1'b1, rc, 1'b1, 1'b0);
        end

        // R8: divider hold and release
        tag = "R8";
        repeat (11) step(1'b1, 4'd4, 1'b1, 1'b0);
        repeat (20) step(1'b1, 4'd4, 1'b1, 1'b1);
        repeat (40) step(1'b1, 4'd4, 1'b1, 1'b0);
        for (int k = 0; k < 2000; k++)
            step(1'b1, 4'd3, 1'b1, ($urandom % 16) == 0);

        // R10: sparse timebase steps
        tag = "R10";
        for (int k = 0; k < 4000; k++)
            step(($urandom % 3) == 0, 4'd3, 1'b1, 1'b0);

        // mixed random
        tag = "R6";
        for (int k = 0; k < 20000; k++)
            step(($urandom % 4) != 0, 4'($urandom % 7), ($urandom % 8) != 0,
                 ($urandom % 64) == 0);

        @(negedge clk);
        check_outputs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule